// File: doc/BRIEF.md
# External Bus Write-Cycle Controller

This block runs write transfers onto an external parallel memory bus, one at a time, using a timing clock. The internal side is a plain request/acknowledge port. When the block is idle and sees a request, it captures the address, the data and the configuration. It then drives one write access, which has three programmable phases: lead, active and trail. The pins are:

- an active-low chip-select;
- an address bus;
- two active-low write strobes;
- a read/not-write line;
- a data bus with an output enable.

The active phase can be stretched by an external ready input. In synchronous mode the ready pin is used directly. In asynchronous mode it first passes through a two-flop synchronizer, so the raw pin is effectively sampled two cycles earlier. A mode input selects either a 32-bit or a 16-bit data bus. In 16-bit mode the second strobe pin carries address bit 0, and the upper data half is driven to zero.

Every access ends with a one-cycle release step. In that cycle chip-select and read/not-write are already high, while the address and data are still held. After the release cycle the bus idles with the last address, except that address bit 0 is forced high.

Top module: `xbus_wr_ctrl`

## Requirements
- R1: While reset is asserted, cs_no, rnw_o and both bits of we_no are 1, data_oe_o and ack_o are 0, and addr_o equals 1 (bit 0 high, all other bits 0).
- R2: A request with req_i high at a clock edge while idle is accepted. From the next cycle, cs_no and rnw_o are 0 and addr_o carries the captured address. The strobes stay high for L = max(lead_i,1) lead cycles.
- R3: The strobe we_no[0] is low for Aeff + W cycles starting at cycle L after acceptance. Aeff = max(active_i,1) in synchronous mode and max(active_i,3) in asynchronous mode. W is the number of ready samples that were low.
- R4: In synchronous mode (async_rdy_i = 0), ready_i is sampled at the edge ending active cycle Aeff, counted from the start of the active phase. If it is low, the active phase grows by one cycle and ready_i is sampled again at each following edge until it is high.
- R5: In asynchronous mode (async_rdy_i = 1), the ready decision at each sampling edge uses the ready_i level from two edges earlier, so the first raw sample falls after L + Aeff − 2 cycles.
- R6: The trail phase lasts max(trail_i,1) cycles. During trail the strobes are high, while cs_no and rnw_o stay low and data stays driven. ack_o is high only in the last trail cycle.
- R7: In the cycle after the trail phase, cs_no and rnw_o are 1, data_oe_o is still 1 and addr_o is unchanged. From the next cycle data_oe_o is 0, and addr_o holds the last address with bit 0 forced to 1.
- R8: In 32-bit mode (bus32_i = 1), we_no[1] equals we_no[0]. In 16-bit mode, we_no[1] equals addr_o[0] and data_o[DATA_W-1:DATA_W/2] is 0.
- R9: data_oe_o rises in the same cycle as the first strobe-low cycle, with data_o equal to the captured write data.
- R10: A request raised during an access is ignored. The running access is unchanged, and chip-select stays high in the idle cycles that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, accepted when idle |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| lead_i | input | CNT_W | Lead phase length in cycles |
| active_i | input | CNT_W | Active phase length in cycles, before ready wait |
| trail_i | input | CNT_W | Trail phase length in cycles |
| async_rdy_i | input | 1 | 1 = asynchronous ready mode, 0 = synchronous |
| bus32_i | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| ready_i | input | 1 | External ready |
| ack_o | output | 1 | Single-cycle completion pulse |
| cs_no | output | 1 | Chip-select, active low |
| addr_o | output | ADDR_W | Address bus |
| we_no | output | 2 | Write strobes, active low; bit 1 is address bit 0 in 16-bit mode |
| rnw_o | output | 1 | Read/not-write, low during a write |
| data_o | output | DATA_W | Write data bus |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
All pin outputs are decoded from registered state. Every pin therefore moves in the cycle whose opening edge changed the state, and the bench compares the whole pin vector once per cycle, at the falling edge. Cycle 0 is the first cycle after the accepting edge. The lead phase covers cycles below L, the strobe is low from L until L+Aeff+W−1, ack_o is due at cycle N−1 with N = L+Aeff+W+Teff, the release comes at N, and the idle address appears from N+1. The bench drives ready_i so that the level the design uses turns high on the W-th resample. In synchronous mode that level is the one present in the sampling cycle; in asynchronous mode it is the one present two cycles earlier. The expected pin vector is computed from these counts alone.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_ACT   = 3'd2,
    ST_TRAIL = 3'd3,
    ST_REL   = 3'd4
  } xbw_state_e;
endpackage

// File: rtl/xbw_rdy_sync.sv
module xbw_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else         sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
  import xbw_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ASYNC_MIN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] active_i,
  input  logic [CNT_W-1:0] trail_i,
  input  logic             async_i,
  input  logic             rdy_i,
  output xbw_state_e       state_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] AMIN = CNT_W'(ASYNC_MIN);

  xbw_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, act_q, trail_q;

  function automatic logic [CNT_W-1:0] at_least(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] m);
    return (v < m) ? m : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act_q   <= ONE;
      trail_q <= ONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          cnt_q   <= at_least(lead_i, ONE) - ONE;
          act_q   <= at_least(active_i, async_i ? AMIN : ONE);
          trail_q <= at_least(trail_i, ONE);
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            state_q <= ST_ACT;
            cnt_q   <= act_q - ONE;
          end else cnt_q <= cnt_q - ONE;
        end
        ST_ACT: begin
          if (cnt_q != '0) cnt_q <= cnt_q - ONE;
          else if (rdy_i) begin
            state_q <= ST_TRAIL;
            cnt_q   <= trail_q - ONE;
          end
        end
        ST_TRAIL: begin
          if (cnt_q == '0) state_q <= ST_REL;
          else             cnt_q   <= cnt_q - ONE;
        end
        ST_REL:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign last_o  = (state_q == ST_TRAIL) && (cnt_q == '0);

  // wait state: low ready at the sample point keeps the active phase
  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && cnt_q == '0 && !rdy_i) |=> (state_q == ST_ACT));
  p_lead_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD) |=> (state_q == ST_LEAD || state_q == ST_ACT));
endmodule

// File: rtl/xbus_wr_ctrl.sv
module xbus_wr_ctrl
  import xbw_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  lead_i,
  input  logic [CNT_W-1:0]  active_i,
  input  logic [CNT_W-1:0]  trail_i,
  input  logic              async_rdy_i,
  input  logic              bus32_i,
  input  logic              ready_i,
  output logic              ack_o,
  output logic              cs_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        we_no,
  output logic              rnw_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int HALF = DATA_W / 2;

  xbw_state_e        state;
  logic              start, rdy_sync, rdy_use, in_acc, strobe_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              bus32_q, async_q;

  assign start = req_i && (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      data_q  <= '0;
      bus32_q <= 1'b1;
      async_q <= 1'b0;
    end else if (start) begin
      addr_q  <= addr_i;
      data_q  <= wdata_i;
      bus32_q <= bus32_i;
      async_q <= async_rdy_i;
    end
  end

  xbw_rdy_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ready_i),
    .q_o   (rdy_sync)
  );

  assign rdy_use = async_q ? rdy_sync : ready_i;

  xbw_seq #(.CNT_W(CNT_W), .ASYNC_MIN(3)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .lead_i  (lead_i),
    .active_i(active_i),
    .trail_i (trail_i),
    .async_i (async_rdy_i),
    .rdy_i   (rdy_use),
    .state_o (state),
    .last_o  (ack_o)
  );

  assign in_acc    = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_TRAIL);
  assign cs_no     = !in_acc;
  assign rnw_o     = !in_acc;
  assign strobe_n  = (state != ST_ACT);
  assign data_oe_o = (state == ST_ACT) || (state == ST_TRAIL) || (state == ST_REL);
  // idle bus: last address, bit 0 parked high
  assign addr_o    = (state == ST_IDLE) ? {addr_q[ADDR_W-1:1], 1'b1} : addr_q;
  assign we_no[0]  = strobe_n;
  assign we_no[1]  = bus32_q ? strobe_n : addr_o[0];
  assign data_o    = bus32_q ? data_q : {{(DATA_W-HALF){1'b0}}, data_q[HALF-1:0]};

  p_strobe_in_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no[0] |-> (!cs_no && !rnw_o && data_oe_o));
  p_ack_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (!ack_o && cs_no && data_oe_o));
  p_data_past_rnw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rnw_o) |-> data_oe_o);
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $stable(addr_o));
  p_idle_a0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !data_oe_o) |-> addr_o[0]);
  p_oe_with_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no[0]) |-> $rose(data_oe_o));
endmodule

// File: tb/xbus_wr_ctrl_tb.sv
module xbus_wr_ctrl_tb;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int VW     = 5 + ADDR_W + DATA_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [CNT_W-1:0]  lead_i = '0, active_i = '0, trail_i = '0;
  logic              async_rdy_i = 1'b0, bus32_i = 1'b1, ready_i = 1'b0;
  logic              ack_o, cs_no, rnw_o, data_oe_o;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        we_no;
  logic [DATA_W-1:0] data_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  xbus_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .lead_i(lead_i), .active_i(active_i),
    .trail_i(trail_i), .async_rdy_i(async_rdy_i), .bus32_i(bus32_i),
    .ready_i(ready_i), .ack_o(ack_o), .cs_no(cs_no), .addr_o(addr_o),
    .we_no(we_no), .rnw_o(rnw_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string tag, input logic [VW-1:0] got,
                     input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  function automatic logic [VW-1:0] pins();
    return {cs_no, rnw_o, we_no[0], data_oe_o, ack_o, addr_o,
            data_o & {DATA_W{data_oe_o}}};
  endfunction

  task automatic run_access(input int idx, input bit b32, input bit asy,
                            input int ld, input int ac, input int tr,
                            input int w);
    int L, Ae, Te, N, c0, rhi;
    bit inj;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d, dm;
    logic [ADDR_W-1:0] ea;
    logic ecs, est, eoe, eack;
    string tag;
    a   = ADDR_W'(idx * 32'h2345 + idx);
    d   = DATA_W'(idx) * 32'h9E3779B1;
    dm  = b32 ? d : {16'h0, d[15:0]};
    L   = (ld < 1) ? 1 : ld;
    Ae  = asy ? ((ac < 3) ? 3 : ac) : ((ac < 1) ? 1 : ac);
    Te  = (tr < 1) ? 1 : tr;
    N   = L + Ae + w + Te;
    c0  = L + Ae - 1;
    rhi = asy ? c0 + w - 2 : c0 + w;
    inj = (idx % 5 == 0);
    req_i = 1'b1; addr_i = a; wdata_i = d;
    lead_i = CNT_W'(ld); active_i = CNT_W'(ac); trail_i = CNT_W'(tr);
    async_rdy_i = asy; bus32_i = b32;
    for (int c = 0; c <= N + 2; c++) begin
      @(negedge clk);
      ecs  = (c >= N);
      est  = !(c >= L && c < L + Ae + w);
      eoe  = (c >= L && c <= N);
      eack = (c == N - 1);
      ea   = (c <= N) ? a : {a[ADDR_W-1:1], 1'b1};
      if (c < L)               tag = "R2 lead";
      else if (c == L)         tag = "R9 strobe/data start";
      else if (c < L + Ae + w) tag = asy ? "R5 async active" : (w > 0 ? "R4 sync wait" : "R3 active");
      else if (c < N)          tag = "R6 trail";
      else if (c == N)         tag = "R7 release";
      else                     tag = inj ? "R10 idle after ignored req" : "R7 idle";
      chk(tag, pins(), {ecs, ecs, est, eoe, eack, ea, dm & {DATA_W{eoe}}});
      chk("R8 second strobe", VW'(we_no[1]), VW'(b32 ? est : ea[0]));
      // drive next-cycle inputs
      req_i   = (inj && c == L);
      if (inj && c == L) addr_i = ~a;
      ready_i = (c >= rhi) && (c < N);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", pins(), {5'b11100, ADDR_W'(1), {DATA_W{1'b0}}});
    chk("R1 reset strobe1", VW'(we_no[1]), VW'(1));
    rst_ni = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int ld = 0; ld < 4; ld++)
          for (int ac = 0; ac < 5; ac++)
            for (int tr = 0; tr < 3; tr++)
              for (int w = 0; w < 3; w++) begin
                run_access(idx, b[0], s[0], ld, ac, tr, w);
                idx++;
              end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule